// File: doc/BRIEF.md
# Control Latch and System Address Decoder

This block sits between a 16-bit-address CPU and its memory and I/O devices. It holds an eight-bit control register that software sets or clears one bit at a time over the serial bit-I/O bus (CRU), and it turns the CPU bus strobes and address into the chip selects for ROM, RAM, a storage card, memory-mapper registers, a video chip and a serial controller. It also produces a protected RAM write strobe and a one-wait-state request.

Three latch bits steer the decode. Bit 0 is an active-low ROM enable, bit 1 turns the memory mapper on, and bit 2 is a user-mode flag. User mode locks software out of the peripherals and, together with a per-page protect bit supplied by the mapper, blocks RAM writes. Writes into the ROM window always land in RAM, so a ROM image can be copied to the RAM underneath it before the ROM is switched off.

Top module: `ctl_dec_top`

## Requirements
- R1: While `rst_ni` is low, all eight `ctl_o` bits are 0.
- R2: On a rising `clk_i` edge with `cru_clk_ni` low and `addr_i[15:6]` equal to 1 (CRU range 0x0040 to 0x007F), `ctl_o[addr_i[3:1]]` takes `cru_bit_i` and every other bit keeps its value. `addr_i[5:4]` and `addr_i[0]` are ignored. No bit changes on any other edge.
- R3: `ctl_o[0]` is the active-low ROM enable, `ctl_o[1]` the mapper enable and `ctl_o[2]` the user flag. `ctl_o[7:3]` have no effect on any select.
- R4: `rom_sel_no` is low exactly when `mem_en_ni` is low, `addr_i` < 0x8000 and `ctl_o[0]` is 0.
- R5: When `mem_en_ni` is low, `ram_sel_no` is low for addresses below 0x8000 if the ROM is disabled or `we_ni` is low. It is low for addresses from 0x8000 upward outside 0xFE00 to 0xFEFF. It is high in every other case.
- R6: During a memory cycle with `ctl_o[2]` = 0, `card_sel_no` is low for 0xFE00 to 0xFE3F and `map_sel_no` is low for 0xFE40 to 0xFE7F.
- R7: During a memory cycle with `ctl_o[2]` = 0 and an address in 0xFE80 to 0xFEBF, `vid_rd_no` is low when `dbin_ni` is low and `vid_wr_no` is low when `we_ni` is low.
- R8: `ser_sel_no` is low when `mem_en_ni` is high, `addr_i` ≤ 0x003F and `ctl_o[2]` = 0.
- R9: While `ctl_o[2]` = 1, `card_sel_no`, `map_sel_no`, `vid_rd_no`, `vid_wr_no` and `ser_sel_no` stay high.
- R10: `pwe_no` equals `we_ni`, except that it is forced high while `protect_i` and `ctl_o[2]` are both 1.
- R11: `wait_o` is 1 exactly when `rom_sel_no` or `card_sel_no` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the control latch |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_en_ni | input | 1 | Low for a memory cycle, high for a CRU cycle |
| we_ni | input | 1 | Active-low memory write strobe |
| dbin_ni | input | 1 | Active-low data-bus-in (read) strobe |
| cru_clk_ni | input | 1 | Active-low CRU write clock |
| addr_i | input | 16 | CPU address |
| cru_bit_i | input | 1 | CRU output data bit |
| protect_i | input | 1 | Write-protect bit of the current page, from the mapper |
| rom_sel_no | output | 1 | ROM chip select, active low |
| ram_sel_no | output | 1 | RAM chip select, active low |
| card_sel_no | output | 1 | Storage card select, active low |
| map_sel_no | output | 1 | Mapper register select, active low |
| vid_rd_no | output | 1 | Video chip read strobe, active low |
| vid_wr_no | output | 1 | Video chip write strobe, active low |
| ser_sel_no | output | 1 | Serial controller select, active low |
| pwe_no | output | 1 | Protected write enable, active low |
| wait_o | output | 1 | One-wait-state request |
| ctl_o | output | 8 | Control latch outputs |

## Verification
A wrong latch bit is visible on `ctl_o` one edge after the CRU write that caused it. If the wrong bit is 0 or 2, the error also shows at once and combinationally on every later memory cycle: ROM and RAM swap places in the low half, or the peripheral selects and protected writes switch their lockout. A write that lands on the wrong index, or a bit disturbed by a neighbouring write, stays wrong until that bit is written again. The bench therefore compares every output on every clock against a model that tracks all eight bits. Decode faults have no hidden state and show in the same cycle as the address that exposes them, so the bench drives addresses on both sides of every window edge.

// File: rtl/ctl_dec_pkg.sv
package ctl_dec_pkg;
  localparam int CTL_ROM_OFF = 0;
  localparam int CTL_MAP_EN  = 1;
  localparam int CTL_USER    = 2;

  // active-high internal select bundle
  typedef struct packed {
    logic rom;
    logic ram;
    logic card;
    logic mapr;
    logic vid_rd;
    logic vid_wr;
    logic ser;
    logic pwe;
    logic wreq;
  } sel_t;
endpackage

// File: rtl/ctl_latch.sv
module ctl_latch #(
  parameter int          WIDTH     = 8,
  parameter int          ADDR_W    = 16,
  parameter int          SPAN_BITS = 6,
  parameter logic [15:0] BASE      = 16'h0040
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cru_clk_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bit_i,
  output logic [WIDTH-1:0]  q_o
);
  localparam int IDX_W = $clog2(WIDTH);
  localparam logic [ADDR_W-SPAN_BITS-1:0] BASE_HI = BASE[ADDR_W-1:SPAN_BITS];

  logic             hit;
  logic [IDX_W-1:0] idx;
  logic             unused_addr;

  assign hit = !cru_clk_ni && (addr_i[ADDR_W-1:SPAN_BITS] == BASE_HI);
  // CRU addresses step by two
  assign idx = addr_i[IDX_W:1];
  assign unused_addr = ^{addr_i[SPAN_BITS-1:IDX_W+1], addr_i[0]};

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            q_o[g] <= 1'b0;
      else if (hit && (idx == IDX_W'(g)))     q_o[g] <= bit_i;
    end
  end

  // R2
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(q_o));
  // R2
  latch_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> q_o[$past(idx)] == $past(bit_i));
  // R2
  latch_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> $countones(q_o ^ $past(q_o)) <= 1);
endmodule

// File: rtl/addr_decode.sv
module addr_decode
  import ctl_dec_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          PAGE_BITS = 8,
  parameter int          WIN_BITS  = 6,
  parameter logic [7:0]  IO_PAGE   = 8'hFE
) (
  input  logic                       mem_en_ni,
  input  logic                       we_ni,
  input  logic                       dbin_ni,
  input  logic [ADDR_W-1:WIN_BITS]   addr_hi_i,
  input  logic                       rom_off_i,
  input  logic                       user_i,
  input  logic                       protect_i,
  output sel_t                       sel_o
);
  localparam int SUB_W = PAGE_BITS - WIN_BITS;
  localparam int PG_W  = ADDR_W - PAGE_BITS;

  logic             mem, upper, io_pg, cru_low, dev_ok;
  logic [SUB_W-1:0] win;

  assign mem     = !mem_en_ni;
  assign upper   = addr_hi_i[ADDR_W-1];
  assign io_pg   = addr_hi_i[ADDR_W-1 -: PG_W] == IO_PAGE[PG_W-1:0];
  assign win     = addr_hi_i[PAGE_BITS-1:WIN_BITS];
  assign cru_low = addr_hi_i == '0;
  assign dev_ok  = mem && io_pg && !user_i;

  always_comb begin
    sel_o        = '0;
    sel_o.rom    = mem && !upper && !rom_off_i;
    // writes under enabled ROM fall through to RAM
    sel_o.ram    = mem && ((!upper && (rom_off_i || !we_ni)) || (upper && !io_pg));
    sel_o.card   = dev_ok && (win == SUB_W'(0));
    sel_o.mapr   = dev_ok && (win == SUB_W'(1));
    sel_o.vid_rd = dev_ok && (win == SUB_W'(2)) && !dbin_ni;
    sel_o.vid_wr = dev_ok && (win == SUB_W'(2)) && !we_ni;
    sel_o.ser    = !mem && cru_low && !user_i;
    sel_o.pwe    = !we_ni && !(protect_i && user_i);
    sel_o.wreq   = sel_o.rom || sel_o.card;
  end
endmodule

// File: rtl/ctl_dec_top.sv
module ctl_dec_top
  import ctl_dec_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LATCH_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mem_en_ni,
  input  logic               we_ni,
  input  logic               dbin_ni,
  input  logic               cru_clk_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               cru_bit_i,
  input  logic               protect_i,
  output logic               rom_sel_no,
  output logic               ram_sel_no,
  output logic               card_sel_no,
  output logic               map_sel_no,
  output logic               vid_rd_no,
  output logic               vid_wr_no,
  output logic               ser_sel_no,
  output logic               pwe_no,
  output logic               wait_o,
  output logic [LATCH_W-1:0] ctl_o
);
  localparam int WIN_BITS = 6;

  logic [LATCH_W-1:0] ctl_q;
  sel_t               sel;

  ctl_latch #(.WIDTH(LATCH_W), .ADDR_W(ADDR_W), .SPAN_BITS(WIN_BITS), .BASE(16'h0040)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cru_clk_ni(cru_clk_ni),
    .addr_i    (addr_i),
    .bit_i     (cru_bit_i),
    .q_o       (ctl_q)
  );

  addr_decode #(.ADDR_W(ADDR_W), .PAGE_BITS(8), .WIN_BITS(WIN_BITS), .IO_PAGE(8'hFE)) u_dec (
    .mem_en_ni(mem_en_ni),
    .we_ni    (we_ni),
    .dbin_ni  (dbin_ni),
    .addr_hi_i(addr_i[ADDR_W-1:WIN_BITS]),
    .rom_off_i(ctl_q[CTL_ROM_OFF]),
    .user_i   (ctl_q[CTL_USER]),
    .protect_i(protect_i),
    .sel_o    (sel)
  );

  assign ctl_o       = ctl_q;
  assign rom_sel_no  = !sel.rom;
  assign ram_sel_no  = !sel.ram;
  assign card_sel_no = !sel.card;
  assign map_sel_no  = !sel.mapr;
  assign vid_rd_no   = !sel.vid_rd;
  assign vid_wr_no   = !sel.vid_wr;
  assign ser_sel_no  = !sel.ser;
  assign pwe_no      = !sel.pwe;
  assign wait_o      = sel.wreq;

  // R9
  user_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q[CTL_USER] |-> (card_sel_no && map_sel_no && vid_rd_no && vid_wr_no && ser_sel_no));
  // R6
  dev_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({!card_sel_no, !map_sel_no, !vid_rd_no, !ser_sel_no}));
  // R10
  wr_protect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (protect_i && ctl_q[CTL_USER]) |-> pwe_no);
  // R11
  wait_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |-> !mem_en_ni);
  // R4
  rom_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q[CTL_ROM_OFF] |-> rom_sel_no);
endmodule

// File: tb/ctl_dec_top_test.sv
module ctl_dec_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        mem_en_ni = 1'b1, we_ni = 1'b1, dbin_ni = 1'b1, cru_clk_ni = 1'b1;
  logic [15:0] addr_i = '0;
  logic        cru_bit_i = 1'b0, protect_i = 1'b0;
  logic        rom_sel_no, ram_sel_no, card_sel_no, map_sel_no, vid_rd_no, vid_wr_no;
  logic        ser_sel_no, pwe_no, wait_o;
  logic [7:0]  ctl_o;

  int n_cmp = 0, n_bad = 0;
  bit m_bits [8];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ctl_dec_top uut (.*);

  task automatic cmp(string tag, string nm, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s addr=%h actual=%h expected=%h", tag, nm, addr_i, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    int a;
    bit mem, user, rom_on, rom, ram, card, mapr, vr, vw, ser, pwe;
    logic [7:0] bits;
    a = int'(addr_i);
    mem = !mem_en_ni; user = m_bits[2]; rom_on = !m_bits[0];
    rom  = mem && a < 'h8000 && rom_on;
    ram  = mem && ((a < 'h8000 && (!rom_on || !we_ni)) ||
                   (a >= 'h8000 && !(a >= 'hFE00 && a <= 'hFEFF)));
    card = mem && !user && a >= 'hFE00 && a <= 'hFE3F;
    mapr = mem && !user && a >= 'hFE40 && a <= 'hFE7F;
    vr   = mem && !user && a >= 'hFE80 && a <= 'hFEBF && !dbin_ni;
    vw   = mem && !user && a >= 'hFE80 && a <= 'hFEBF && !we_ni;
    ser  = !mem && !user && a <= 'h3F;
    pwe  = !we_ni && !(protect_i && user);
    for (int i = 0; i < 8; i++) bits[i] = m_bits[i];
    cmp({tag, "/R2"},  "ctl_o",       ctl_o,       bits);
    cmp({tag, "/R4"},  "rom_sel_no",  8'(rom_sel_no),  8'(!rom));
    cmp({tag, "/R5"},  "ram_sel_no",  8'(ram_sel_no),  8'(!ram));
    cmp({tag, "/R6"},  "card_sel_no", 8'(card_sel_no), 8'(!card));
    cmp({tag, "/R6"},  "map_sel_no",  8'(map_sel_no),  8'(!mapr));
    cmp({tag, "/R7"},  "vid_rd_no",   8'(vid_rd_no),   8'(!vr));
    cmp({tag, "/R7"},  "vid_wr_no",   8'(vid_wr_no),   8'(!vw));
    cmp({tag, "/R8"},  "ser_sel_no",  8'(ser_sel_no),  8'(!ser));
    cmp({tag, "/R10"}, "pwe_no",      8'(pwe_no),      8'(!pwe));
    cmp({tag, "/R11"}, "wait_o",      8'(wait_o),      8'(rom || card));
  endtask

  task automatic step(string tag, bit men, bit we, bit db, bit cc, int a, bit b, bit p);
    mem_en_ni = men; we_ni = we; dbin_ni = db; cru_clk_ni = cc;
    addr_i = 16'(a); cru_bit_i = b; protect_i = p;
    @(negedge clk_i);
    check_all(tag);
    @(posedge clk_i);
    if (rst_ni && !cc && a >= 'h40 && a <= 'h7F) m_bits[(a >> 1) & 7] = b;
    #1;
  endtask

  task automatic cru_wr(string tag, int a, bit b);
    step(tag, 1, 1, 1, 0, a, b, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_bits[i] = 0;
    // R1: writes attempted during reset must not stick
    step("R1", 1, 1, 1, 0, 'h0042, 1, 0);
    step("R1", 0, 1, 0, 1, 'h1000, 0, 0);
    rst_ni = 1'b1;
    #1;
    // R4 R5: ROM enabled, read and write under ROM
    step("R4", 0, 1, 0, 1, 'h0000, 0, 0);
    step("R5", 0, 0, 1, 1, 'h7FFF, 0, 0);
    step("R5", 0, 1, 0, 1, 'h8000, 0, 0);
    step("R5", 0, 1, 0, 1, 'hFDFF, 0, 0);
    step("R5", 0, 1, 0, 1, 'hFF00, 0, 0);
    step("R5", 0, 1, 0, 1, 'hFEC0, 0, 0);
    // R6 R7 R11: window edges
    step("R6", 0, 1, 0, 1, 'hFE00, 0, 0);
    step("R6", 0, 1, 0, 1, 'hFE3F, 0, 0);
    step("R6", 0, 0, 1, 1, 'hFE40, 0, 0);
    step("R6", 0, 1, 0, 1, 'hFE7F, 0, 0);
    step("R7", 0, 1, 0, 1, 'hFE80, 0, 0);
    step("R7", 0, 0, 1, 1, 'hFEBF, 0, 0);
    step("R7", 0, 1, 1, 1, 'hFE90, 0, 0);
    // R8: CRU cycles
    step("R8", 1, 1, 1, 1, 'h0000, 0, 0);
    step("R8", 1, 1, 1, 1, 'h003F, 0, 0);
    step("R8", 1, 1, 1, 1, 'h0040, 0, 0);
    step("R8", 0, 1, 0, 1, 'h0010, 0, 0);
    // R2: CRU clock high does not write; aliasing on bits 5:4
    step("R2", 1, 1, 1, 1, 'h0040, 1, 0);
    cru_wr("R2", 'h0040, 1);
    step("R4", 0, 1, 0, 1, 'h0100, 0, 0);
    step("R5", 0, 1, 0, 1, 'h0100, 0, 0);
    cru_wr("R2", 'h0070, 0);
    cru_wr("R2", 'h005A, 1);
    cru_wr("R2", 'h0080, 1);
    cru_wr("R2", 'h003E, 1);
    // R3: spare bits do not move any select
    for (int k = 3; k < 8; k++) cru_wr("R3", 'h40 + 2*k, 1);
    step("R3", 0, 1, 0, 1, 'h2000, 0, 0);
    step("R3", 0, 1, 0, 1, 'hFE20, 0, 0);
    cru_wr("R3", 'h0042, 1);
    step("R3", 0, 1, 0, 1, 'hFE50, 0, 0);
    // R9 R10: user mode
    cru_wr("R9", 'h0044, 1);
    step("R9", 0, 1, 0, 1, 'hFE00, 0, 0);
    step("R9", 0, 0, 1, 1, 'hFE40, 0, 0);
    step("R9", 0, 0, 0, 1, 'hFE80, 0, 0);
    step("R9", 1, 1, 1, 1, 'h0008, 0, 0);
    step("R10", 0, 0, 1, 1, 'h9000, 0, 1);
    step("R10", 0, 0, 1, 1, 'h9000, 0, 0);
    cru_wr("R10", 'h004C, 0);
    step("R10", 0, 0, 1, 1, 'h9000, 0, 1);
    cru_wr("R9", 'h0064, 0);
    step("R10", 0, 0, 1, 1, 'h9000, 0, 1);
    step("R9", 1, 1, 1, 1, 'h0008, 0, 0);
    // mixed pseudo-random traffic
    for (int n = 0; n < 4000; n++) begin
      int a, cls;
      cls = $urandom_range(0, 5);
      case (cls)
        0: a = $urandom_range(0, 'h7FFF);
        1: a = $urandom_range('h8000, 'hFFFF);
        2: a = 'hFE00 + $urandom_range(0, 'hFF);
        3: a = $urandom_range('h30, 'h8F);
        default: a = $urandom_range(0, 'hFFFF);
      endcase
      step("RND", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a,
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule